// File: doc/BRIEF.md
# Serial Channel Configuration Register File

This block is the host-facing register file of one asynchronous serial channel. The host sees two byte ports. The first is a control/status port. The second is a data port. Every configuration register sits behind the control port and is reached through a pointer.

A control write made while the pointer is zero loads a new pointer value and may also carry a command. The next control write stores its byte into the register that the pointer selects, and the pointer then returns to zero. A control read always returns a status byte built from live channel flags. Only one command is decoded: a channel reset. It disables both directions, clears the pointer and settles the data-path flags, while the interrupt vector survives.

The block also holds the one-byte receive and transmit buffers. It splits the stored configuration into the fields that a separate shifter consumes:
- character length, enable and parity for each direction;
- stop-bit selection;
- clock divider selection;
- interrupt enables and interrupt vector.

Top module: `serial_cfg_regs`

## Requirements
- R1: After `rst_n` is sampled low, the status byte reads 0x04, every decoded configuration output and `int_vec` are 0, `irq` and `tx_full` are 0, and the pointer is 0.
- R2: A control write while the pointer is 0 loads the pointer from `wdata[2:0]`. The next control write stores `wdata` into the selected register, and the pointer returns to 0, so the write after that is again a pointer write.
- R3: A control read with no control write in the same cycle returns the status byte and clears a non-zero pointer. A byte written after that read is therefore taken as a pointer write and not as register data.
- R4: A control write while the pointer is 0 with `wdata[5:3]` = 3'b011 (for example 0x18) is a channel reset. It clears the pointer, register 3 bit 0 and register 5 bit 3, clears receive-available and sets transmit-empty. All other stored bits, including register 2, keep their values. The channel reset takes priority over data-port and receiver activity in the same cycle.
- R5: The status byte carries the following, and bits 3, 4 and 6 read 0:
  - bit 0: receive-available;
  - bit 1: interrupt pending;
  - bit 2: transmit-empty;
  - bit 5: synchronized CTS;
  - bit 7: `rx_break` as presented this cycle.
- R6: With the receiver enabled, `rx_push` stores `rx_char` into the receive buffer and sets receive-available. With the receiver disabled, `rx_push` changes neither the buffer nor the flag. A data-port read clears receive-available. When a push and a read fall in the same cycle, the push wins.
- R7: A data-port write stores `wdata` into `tx_char` and clears transmit-empty (`tx_full` = 1). `tx_take` sets transmit-empty. When a write and a take fall in the same cycle, the write wins.
- R8: Status bit 5 follows `cts_in` through two flip-flops. A change on `cts_in` shows after the second rising clock edge, and not after the first.
- R9: `irq` and status bit 1 are 1 when either of these holds:
  - register 1 bit 0 is set and receive-available is 1;
  - register 1 bit 1 is set, transmit-empty is 1 and the transmitter is enabled.
- R10: `int_vec` always equals register 2. It changes only through a data write to register 2.
- R11: The configuration outputs are decoded from the registers as follows:
  - `rx_en` = reg3[0] and `rx_bits` = reg3[7:6];
  - `tx_en` = reg5[3] and `tx_bits` = reg5[6:5];
  - `par_en` = reg4[0], `par_even` = reg4[1], `stop_sel` = reg4[3:2] and `clk_sel` = reg4[7:6].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Control port write strobe |
| ctl_rd | input | 1 | Control port read strobe |
| data_wr | input | 1 | Data port write strobe (loads transmit buffer) |
| data_rd | input | 1 | Data port read strobe (consumes received byte) |
| wdata | input | 8 | Write data for both ports |
| ctl_rdata | output | 8 | Status byte |
| data_rdata | output | 8 | Received character |
| rx_push | input | 1 | Receiver delivers a character |
| rx_char | input | 8 | Character from the receiver |
| rx_break | input | 1 | Break/abort flag from the receiver |
| tx_take | input | 1 | Transmitter has taken the buffered byte |
| tx_char | output | 8 | Buffered transmit byte |
| tx_full | output | 1 | Transmit buffer holds a byte |
| cts_in | input | 1 | Asynchronous clear-to-send line |
| rx_en | output | 1 | Receiver enable |
| rx_bits | output | 2 | Receive character length code |
| tx_en | output | 1 | Transmitter enable |
| tx_bits | output | 2 | Transmit character length code |
| par_en | output | 1 | Parity enable |
| par_even | output | 1 | Even parity select |
| stop_sel | output | 2 | Stop bit selection |
| clk_sel | output | 2 | Clock divider selection |
| irq | output | 1 | Interrupt request |
| int_vec | output | 8 | Interrupt vector byte |

## Verification
The bench builds the block with its default parameters:
- a 3-bit pointer, giving eight write registers of which five are decoded;
- a two-stage CTS synchronizer.

With a 3-bit pointer, every decoded register and the two undecoded ones can be reached. This lets a table of pointer/data pairs exercise each field decode and check that the pointer returns to zero after every pair. The two-stage depth makes the one-edge and two-edge CTS observations exact. The directed part covers the collision orders, a channel reset issued with and without a pending pointer, and the pointer abandoned by a status read.

// File: rtl/serial_cfg_pkg.sv
// Shared constants for the serial configuration register file.
// Assumes byte-wide registers; register indices and bit positions are
// the ones decoded by the neighbouring shifter logic.
package serial_cfg_pkg;

    localparam int BYTE_W = 8;

    // register indices
    localparam int REG_IEN = 1;
    localparam int REG_VEC = 2;
    localparam int REG_RX  = 3;
    localparam int REG_FMT = 4;
    localparam int REG_TX  = 5;

    // enable bits cleared by a channel reset
    localparam int RX_EN_BIT = 0;
    localparam int TX_EN_BIT = 3;

    // status bit positions
    localparam int ST_RXA = 0;
    localparam int ST_INT = 1;
    localparam int ST_TXE = 2;
    localparam int ST_CTS = 5;
    localparam int ST_BRK = 7;

    typedef enum logic [2:0] {
        CMD_NONE       = 3'd0,
        CMD_CHAN_RESET = 3'd3
    } cmd_e;

    // Bits of a register kept across a channel reset.
    function automatic logic [BYTE_W-1:0] keep_mask(input int idx);
        logic [BYTE_W-1:0] m;
        m = '1;
        if (idx == REG_RX) m[RX_EN_BIT] = 1'b0;
        if (idx == REG_TX) m[TX_EN_BIT] = 1'b0;
        return m;
    endfunction

endpackage

// File: rtl/serial_cfg_ptr_seq.sv
// Pointer sequencer: turns control-port writes into either a pointer
// load / command or a register write, and decodes the channel reset.
// Assumes ctl_wr wins over ctl_rd in the same cycle.
module serial_cfg_ptr_seq #(
    parameter int PTR_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic             ctl_rd,
    input  logic [7:0]       wdata,
    output logic [PTR_W-1:0] ptr_q,
    output logic             reg_we,
    output logic             chan_reset
);
    import serial_cfg_pkg::*;

    logic ptr_zero;
    logic unused_wdata;

    // pointer-zero decode and command/write qualification
    always_comb begin
        ptr_zero     = (ptr_q == '0);
        reg_we       = ctl_wr && !ptr_zero;
        chan_reset   = ctl_wr && ptr_zero && (wdata[5:3] == CMD_CHAN_RESET);
        unused_wdata = ^wdata[7:6];
    end

    // pointer register: load on pointer write, clear after any other access
    always_ff @(posedge clk) begin
        if (!rst_n)          ptr_q <= '0;
        else if (chan_reset) ptr_q <= '0;
        else if (ctl_wr)     ptr_q <= ptr_zero ? wdata[PTR_W-1:0] : '0;
        else if (ctl_rd)     ptr_q <= '0;
    end

endmodule

// File: rtl/serial_cfg_wreg_bank.sv
// Write-register storage, one byte per pointer value. Entry 0 is not
// stored (it is the pointer/command register) and reads as zero.
// Assumes a channel reset and a register write never coincide (both
// need different pointer states).
module serial_cfg_wreg_bank #(
    parameter int PTR_W = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [PTR_W-1:0]       sel,
    input  logic [7:0]             wdata,
    input  logic                   chan_reset,
    output logic [(1<<PTR_W)-1:0][7:0] regs
);
    import serial_cfg_pkg::*;

    localparam int NREG = 1 << PTR_W;

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        if (i == 0) begin : g_none
            assign regs[i] = '0;
        end else begin : g_byte
            localparam logic [7:0] KEEP = keep_mask(i);
            // one configuration byte: write, partial clear on channel reset
            always_ff @(posedge clk) begin
                if (!rst_n)                          regs[i] <= '0;
                else if (chan_reset)                 regs[i] <= regs[i] & KEEP;
                else if (we && sel == PTR_W'(i))     regs[i] <= wdata;
            end
        end
    end

endmodule

// File: rtl/serial_cfg_status.sv
// Data-path flags and status byte: receive/transmit buffers, their
// flags, CTS synchronizer and interrupt-pending logic.
// Assumes SYNC_STAGES >= 2 and rx_break already synchronous.
module serial_cfg_status #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       chan_reset,
    input  logic       rx_en,
    input  logic       tx_en,
    input  logic [1:0] ien,
    input  logic       rx_push,
    input  logic [7:0] rx_char,
    input  logic       rx_break,
    input  logic       data_rd,
    input  logic       data_wr,
    input  logic [7:0] wdata,
    input  logic       tx_take,
    input  logic       cts_in,
    output logic [7:0] status,
    output logic [7:0] rx_hold,
    output logic [7:0] tx_hold,
    output logic       tx_empty,
    output logic       irq
);
    import serial_cfg_pkg::*;

    logic                   rx_avail;
    logic [SYNC_STAGES-1:0] cts_q;

    // receive buffer and available flag; a push beats a read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_hold  <= '0;
            rx_avail <= 1'b0;
        end else if (chan_reset) begin
            rx_avail <= 1'b0;
        end else if (rx_push && rx_en) begin
            rx_hold  <= rx_char;
            rx_avail <= 1'b1;
        end else if (data_rd) begin
            rx_avail <= 1'b0;
        end
    end

    // transmit buffer and empty flag; a write beats a take
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_hold  <= '0;
            tx_empty <= 1'b1;
        end else if (chan_reset) begin
            tx_empty <= 1'b1;
        end else if (data_wr) begin
            tx_hold  <= wdata;
            tx_empty <= 1'b0;
        end else if (tx_take) begin
            tx_empty <= 1'b1;
        end
    end

    // CTS synchronizer shift chain
    always_ff @(posedge clk) begin
        if (!rst_n) cts_q <= '0;
        else        cts_q <= {cts_q[SYNC_STAGES-2:0], cts_in};
    end

    // interrupt pending and status byte assembly
    always_comb begin
        irq            = (ien[0] && rx_avail) || (ien[1] && tx_empty && tx_en);
        status         = '0;
        status[ST_RXA] = rx_avail;
        status[ST_INT] = irq;
        status[ST_TXE] = tx_empty;
        status[ST_CTS] = cts_q[SYNC_STAGES-1];
        status[ST_BRK] = rx_break;
    end

endmodule

// File: rtl/serial_cfg_regs.sv
// Top of the serial channel register file: pointer sequencer, register
// bank and status/data flags, plus field decode toward the shifter.
// Assumes PTR_W >= 3 so that all decoded registers are addressable.
module serial_cfg_regs #(
    parameter int PTR_W       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_wr,
    input  logic       ctl_rd,
    input  logic       data_wr,
    input  logic       data_rd,
    input  logic [7:0] wdata,
    output logic [7:0] ctl_rdata,
    output logic [7:0] data_rdata,
    input  logic       rx_push,
    input  logic [7:0] rx_char,
    input  logic       rx_break,
    input  logic       tx_take,
    output logic [7:0] tx_char,
    output logic       tx_full,
    input  logic       cts_in,
    output logic       rx_en,
    output logic [1:0] rx_bits,
    output logic       tx_en,
    output logic [1:0] tx_bits,
    output logic       par_en,
    output logic       par_even,
    output logic [1:0] stop_sel,
    output logic [1:0] clk_sel,
    output logic       irq,
    output logic [7:0] int_vec
);
    import serial_cfg_pkg::*;

    localparam int NREG = 1 << PTR_W;

    logic [PTR_W-1:0]     ptr_q;
    logic                 reg_we;
    logic                 chan_reset;
    logic [NREG-1:0][7:0] regs;
    logic                 tx_empty;
    logic                 unused_cfg;

    serial_cfg_ptr_seq #(.PTR_W(PTR_W)) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_wr     (ctl_wr),
        .ctl_rd     (ctl_rd),
        .wdata      (wdata),
        .ptr_q      (ptr_q),
        .reg_we     (reg_we),
        .chan_reset (chan_reset)
    );

    serial_cfg_wreg_bank #(.PTR_W(PTR_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (reg_we),
        .sel        (ptr_q),
        .wdata      (wdata),
        .chan_reset (chan_reset),
        .regs       (regs)
    );

    serial_cfg_status #(.SYNC_STAGES(SYNC_STAGES)) u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .chan_reset (chan_reset),
        .rx_en      (rx_en),
        .tx_en      (tx_en),
        .ien        (regs[REG_IEN][1:0]),
        .rx_push    (rx_push),
        .rx_char    (rx_char),
        .rx_break   (rx_break),
        .data_rd    (data_rd),
        .data_wr    (data_wr),
        .wdata      (wdata),
        .tx_take    (tx_take),
        .cts_in     (cts_in),
        .status     (ctl_rdata),
        .rx_hold    (data_rdata),
        .tx_hold    (tx_char),
        .tx_empty   (tx_empty),
        .irq        (irq)
    );

    // field decode toward the receiver and transmitter
    always_comb begin
        rx_en    = regs[REG_RX][RX_EN_BIT];
        rx_bits  = regs[REG_RX][7:6];
        tx_en    = regs[REG_TX][TX_EN_BIT];
        tx_bits  = regs[REG_TX][6:5];
        par_en   = regs[REG_FMT][0];
        par_even = regs[REG_FMT][1];
        stop_sel = regs[REG_FMT][3:2];
        clk_sel  = regs[REG_FMT][7:6];
        int_vec  = regs[REG_VEC];
        tx_full  = !tx_empty;
    end

    // fold of stored bits that no output decodes
    always_comb begin
        unused_cfg = ^{regs[0], regs[REG_IEN][7:2], regs[REG_RX][5:1],
                       regs[REG_FMT][5:4], regs[REG_TX][7], regs[REG_TX][4],
                       regs[REG_TX][2:0]};
        for (int i = REG_TX + 1; i < NREG; i++) unused_cfg = unused_cfg ^ (^regs[i]);
    end

endmodule

// File: rtl/serial_cfg_regs_chk.sv
// Protocol checker for serial_cfg_regs, bound to every instance.
// Watches the ports plus the pointer and the decoded channel reset.
module serial_cfg_regs_chk #(
    parameter int PTR_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctl_wr,
    input logic             ctl_rd,
    input logic             data_wr,
    input logic             data_rd,
    input logic [7:0]       wdata,
    input logic             rx_push,
    input logic [7:0]       rx_char,
    input logic             cts_in,
    input logic [7:0]       ctl_rdata,
    input logic [7:0]       data_rdata,
    input logic [7:0]       tx_char,
    input logic             tx_full,
    input logic             rx_en,
    input logic             tx_en,
    input logic [7:0]       int_vec,
    input logic [PTR_W-1:0] ptr_q,
    input logic             chan_reset
);
    import serial_cfg_pkg::*;

    // R2
    ptr_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ptr_q != '0) |=> (ptr_q == '0));

    // R3
    rd_clears_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rd && !ctl_wr) |=> (ptr_q == '0));

    // R4
    chan_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chan_reset |=> (!rx_en && !tx_en && !ctl_rdata[ST_RXA] && ctl_rdata[ST_TXE]
                        && ptr_q == '0 && $stable(int_vec)));

    // R6
    rx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_en && !chan_reset) |=> (ctl_rdata[ST_RXA] && data_rdata == $past(rx_char)));

    // R6
    rx_consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !rx_push) |=> !ctl_rdata[ST_RXA]);

    // R7
    tx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !chan_reset) |=> (tx_full && tx_char == $past(wdata)));

    // R8
    cts_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_rdata[ST_CTS]) |-> $past(cts_in, 2));

    // R10
    vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl_wr && ptr_q == PTR_W'(REG_VEC)) |=> $stable(int_vec));

endmodule

bind serial_cfg_regs serial_cfg_regs_chk #(.PTR_W(PTR_W)) u_chk (.*);

// File: tb/test_serial_cfg_regs.sv
module test_serial_cfg_regs;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 0, ctl_rd = 0, data_wr = 0, data_rd = 0;
    logic [7:0] wdata = 0;
    logic [7:0] ctl_rdata, data_rdata, tx_char, int_vec;
    logic       rx_push = 0, rx_break = 0, tx_take = 0, cts_in = 0;
    logic [7:0] rx_char = 0;
    logic       tx_full, rx_en, tx_en, par_en, par_even, irq;
    logic [1:0] rx_bits, tx_bits, stop_sel, clk_sel;

    int checks = 0;
    int errors = 0;
    logic [7:0] m [8];

    always #4 clk = ~clk;

    serial_cfg_regs i_serial_cfg_regs (.*);

    // {register index, data byte}
    localparam int NV = 14;
    localparam logic [10:0] VEC [NV] = '{
        {3'd3, 8'hC1}, {3'd5, 8'hE8}, {3'd4, 8'h44}, {3'd1, 8'h02},
        {3'd4, 8'h4F}, {3'd2, 8'hA0}, {3'd3, 8'h41}, {3'd5, 8'hA8},
        {3'd4, 8'h0D}, {3'd1, 8'h01}, {3'd3, 8'h80}, {3'd5, 8'h00},
        {3'd2, 8'h5A}, {3'd1, 8'h00}
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] st(logic rxa, logic ip, logic txe, logic cts, logic brk);
        return {brk, 1'b0, cts, 2'b00, txe, ip, rxa};
    endfunction

    function automatic logic [31:0] fields();
        return {10'd0, rx_en, rx_bits, tx_en, tx_bits, par_en, par_even,
                stop_sel, clk_sel, int_vec};
    endfunction

    function automatic logic [31:0] model_fields();
        return {10'd0, m[3][0], m[3][7:6], m[5][3], m[5][6:5], m[4][0], m[4][1],
                m[4][3:2], m[4][7:6], m[2]};
    endfunction

    task automatic ctl_write(logic [7:0] d);
        @(negedge clk); ctl_wr = 1; wdata = d;
        @(negedge clk); ctl_wr = 0;
    endtask

    task automatic reg_write(int idx, logic [7:0] d);
        ctl_write(8'(idx));
        ctl_write(d);
        m[idx] = d;
    endtask

    task automatic pulse(ref logic sig);
        @(negedge clk); sig = 1;
        @(negedge clk); sig = 0;
    endtask

    initial begin
        #1500000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        foreach (m[i]) m[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 status", ctl_rdata, 8'h04);
        check("R1 fields", fields(), 32'd0);
        check("R1 irq/tx_full", {irq, tx_full}, 2'b00);

        // R11 / R2 / R10 table walk; each pair also proves the pointer returned
        for (int k = 0; k < NV; k++) begin
            reg_write(int'(VEC[k][10:8]), VEC[k][7:0]);
            check("R11 decode", fields(), model_fields());
            check("R9 irq", irq, m[1][1] & m[5][3]);
            check("R5 status", ctl_rdata, st(0, m[1][1] & m[5][3], 1, 0, 0));
        end

        // R2: pointer write carrying ptr 0 must not disturb registers
        ctl_write(8'h00);
        check("R2 null pointer write", fields(), model_fields());
        reg_write(2, 8'h33);
        check("R2 vector after pair", int_vec, 8'h33);

        // R3: read abandons pointer, next byte is a pointer write (ptr 5, cmd 2)
        ctl_write(8'h02);
        pulse(ctl_rd);
        ctl_write(8'h55);
        check("R3 abandoned pointer", int_vec, 8'h33);
        pulse(ctl_rd);
        check("R3 pointer cleared", fields(), model_fields());

        // R6: receiver disabled ignores pushes
        @(negedge clk); rx_char = 8'hE7; rx_push = 1;
        @(negedge clk); rx_push = 0;
        check("R6 push ignored flag", ctl_rdata[0], 1'b0);
        check("R6 push ignored data", data_rdata, 8'h00);
        reg_write(3, 8'hC1);
        @(negedge clk); rx_char = 8'h3C; rx_push = 1;
        @(negedge clk); rx_push = 0;
        check("R6 push data", data_rdata, 8'h3C);
        check("R5 status rx", ctl_rdata, st(1, 0, 1, 0, 0));
        pulse(data_rd);
        check("R6 read clears", ctl_rdata[0], 1'b0);
        @(negedge clk); rx_char = 8'h81; rx_push = 1; data_rd = 1;
        @(negedge clk); rx_push = 0; data_rd = 0;
        check("R6 push beats read", {ctl_rdata[0], data_rdata}, {1'b1, 8'h81});

        // R9: receive interrupt enable
        reg_write(1, 8'h01);
        check("R9 rx irq", {irq, ctl_rdata[1]}, 2'b11);
        pulse(data_rd);
        check("R9 rx irq drop", irq, 1'b0);

        // R7: transmit buffer
        @(negedge clk); wdata = 8'h96; data_wr = 1;
        @(negedge clk); data_wr = 0;
        check("R7 tx load", {tx_full, tx_char}, {1'b1, 8'h96});
        check("R5 status tx full", ctl_rdata, st(0, 0, 0, 0, 0));
        pulse(tx_take);
        check("R7 take empties", tx_full, 1'b0);
        @(negedge clk); wdata = 8'h4B; data_wr = 1; tx_take = 1;
        @(negedge clk); data_wr = 0; tx_take = 0;
        check("R7 write beats take", {tx_full, tx_char}, {1'b1, 8'h4B});

        // R9: transmit interrupt needs enable and tx_en
        pulse(tx_take);
        reg_write(1, 8'h02);
        check("R9 tx irq off while tx disabled", irq, 1'b0);
        reg_write(5, 8'hE8);
        check("R9 tx irq", irq, 1'b1);

        // R8: CTS two-flop
        @(negedge clk); cts_in = 1;
        @(negedge clk);
        check("R8 cts one edge", ctl_rdata[5], 1'b0);
        @(negedge clk);
        check("R8 cts two edges", ctl_rdata[5], 1'b1);

        // R5: break is live, unused bits zero
        @(negedge clk); rx_break = 1; #1;
        check("R5 break status", ctl_rdata, st(0, 1, 1, 1, 1));
        @(negedge clk); rx_break = 0; cts_in = 0;
        repeat (2) @(negedge clk);

        // R4: channel reset
        reg_write(2, 8'hA0);
        @(negedge clk); rx_char = 8'h11; rx_push = 1; wdata = 8'h22; data_wr = 1;
        @(negedge clk); rx_push = 0; data_wr = 0;
        ctl_write(8'h18);
        m[3][0] = 1'b0; m[5][3] = 1'b0;
        check("R4 reset fields", fields(), model_fields());
        check("R4 reset flags", {ctl_rdata, tx_full}, {st(0, 0, 1, 0, 0), 1'b0});
        check("R10 vector kept", int_vec, 8'hA0);
        // R4: 0x18 with a pending pointer is register data, not a reset
        reg_write(3, 8'h18);
        check("R4 pointer pending no reset", fields(), model_fields());

        // R1 again via reset pin
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        @(negedge clk);
        check("R1 reset pin", {fields(), ctl_rdata}, {32'd0, 8'h04} );

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule